// File: doc/BRIEF.md
# Privilege-Level System Access Checker

This block rules on every system-register or system-instruction access before it reaches the register file. It looks at the encoding fields of the access, the current privilege level (0 to 3) and the security state. It also looks at a handful of hypervisor and feature controls. From these it decides one of three outcomes: the access goes ahead, the access is undefined, or the access traps to level 2 with a fixed syndrome class.

The minimum privilege level comes from the op1 field. Three further rules are layered on that level:

- a hypervisor trap on the reserved control space;
- a nested-virtualization escape that lets level 1 reach level-2 registers;
- a secure-only class.

The block also computes, on its own output, whether allocation-tag access is enabled at the current level.

All outputs are registered, so they reflect the inputs sampled at the previous clock edge. The crm, op2 and read-direction fields play no part in any of these rules, so they are not ports. The register read and write datapath sits outside the block.

Top module: `sysacc_priv_checker`

## Requirements
- R1: While rst is high at a clock edge, the next outputs are all 0: allowed, undef, trap_l2, syndrome and tag_ok.
- R2: Each output changes only at a rising clock edge. It shows the result for the inputs present at that edge.
- R3: The access traps (trap_l2=1, syndrome=6'h18) when all of the following hold:
  - cur_lvl is 1;
  - hyp_en=1;
  - trap_rsvd=1;
  - op0 bit 0 is 1;
  - crn matches 1x11 (bits 3, 1 and 0 are 1).
- R4: At level 0, the same condition traps only when strap_l0_trap=1. Otherwise the access gets the normal level checks.
- R5: The minimum level depends on op1:
  - op1 000, 001 and 010 need level 1;
  - op1 011 needs level 0;
  - op1 100 needs level 2;
  - op1 110 needs level 3.
  A current level below the minimum gives undef=1. Otherwise the access is allowed.
- R6: op1=101 needs level 2. It gives undef=1 at every level when feat_vhe=0.
- R7: op1=111 needs level 1. When that level is met and secure=0, the access gives undef=1.
- R8: An access below its minimum is not undefined when all of the following hold:
  - feat_nv=1;
  - the minimum level is 2;
  - cur_lvl is 1;
  - hyp_en=1;
  - nv_bit=1.
  Such an access is allowed.
- R9: Outside reset, exactly one of allowed, undef and trap_l2 is 1. Trap wins over undef, and undef wins over allowed. syndrome is 0 unless trap_l2=1.
- R10: tag_ok is 0 in either of these cases:
  - mon_tag_en=0 at levels 0 to 2;
  - hyp_tag_en=0 at levels 0 or 1, with hyp_en=1 and host_pair not 2'b11.
- R11: Otherwise tag_ok follows the enable bit for the current level:
  - l3_tag_en, l2_tag_en or l1_tag_en at levels 3, 2 and 1;
  - at level 0, l2_tag_en0 when hyp_en=1 and host_pair=2'b11, else l1_tag_en0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field crn |
| cur_lvl | input | 2 | Current privilege level |
| secure | input | 1 | Access made in the secure state |
| hyp_en | input | 1 | Hypervisor level enabled |
| trap_rsvd | input | 1 | Trap reserved control space to level 2 |
| nv_bit | input | 1 | Nested-virtualization control |
| host_pair | input | 2 | Host-extension control pair |
| feat_vhe | input | 1 | Host extension present |
| feat_nv | input | 1 | Nested virtualization present |
| strap_l0_trap | input | 1 | Level-0 reserved-space accesses trap |
| mon_tag_en | input | 1 | Monitor tag-access enable |
| hyp_tag_en | input | 1 | Hypervisor tag-access enable |
| l3_tag_en | input | 1 | Level-3 tag enable |
| l2_tag_en | input | 1 | Level-2 tag enable |
| l1_tag_en | input | 1 | Level-1 tag enable |
| l2_tag_en0 | input | 1 | Level-0 tag enable held in level-2 control |
| l1_tag_en0 | input | 1 | Level-0 tag enable held in level-1 control |
| allowed | output | 1 | Access may proceed |
| undef | output | 1 | Access is undefined |
| trap_l2 | output | 1 | Access traps to level 2 |
| syndrome | output | 6 | Trap syndrome class |
| tag_ok | output | 1 | Allocation-tag access enabled |

## Verification
The reserved-space trap and the undefined verdict can both apply to the same access. This happens, for example, at level 1 with op1=110 and crn=1011, or at level 0 with the trap strap set and op1=100. The bench provokes this overlap on purpose in its sweep and in its random vectors. It judges the overlap by requiring the trap output alone, with syndrome 6'h18. The nested-virtualization escape is likewise crossed with the trap, so that the escape cannot hide a trap.

// File: rtl/sysacc_pkg.sv
package sysacc_pkg;
  localparam int LVL_W = 2;

  // Result of decoding op1 into a privilege floor.
  typedef struct packed {
    logic [LVL_W-1:0] min_lvl;   // lowest level that may issue the access
    logic             need_sec;  // access class restricted to secure state
    logic             feat_gap;  // encoding needs an absent feature
  } acc_dec_t;
endpackage

// File: rtl/sysacc_min_level.sv
module sysacc_min_level
  import sysacc_pkg::*;
(
  input  logic [2:0] op1,
  input  logic       feat_vhe,
  output acc_dec_t   dec
);
  always_comb begin
    dec = '{min_lvl: 2'd1, need_sec: 1'b0, feat_gap: 1'b0};
    unique case (op1)
      3'b000, 3'b001, 3'b010: dec.min_lvl = 2'd1;
      3'b011: dec.min_lvl = 2'd0;
      3'b100: dec.min_lvl = 2'd2;
      3'b101: begin
        dec.min_lvl  = 2'd2;
        dec.feat_gap = !feat_vhe;
      end
      3'b110: dec.min_lvl = 2'd3;
      3'b111: begin
        dec.min_lvl  = 2'd1;
        dec.need_sec = 1'b1;
      end
      default: dec.min_lvl = 2'd1;
    endcase
  end
endmodule

// File: rtl/sysacc_rsvd_trap.sv
module sysacc_rsvd_trap
  import sysacc_pkg::*;
(
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic [1:0]       op0,
  input  logic [3:0]       crn,
  input  logic             hyp_en,
  input  logic             trap_rsvd,
  input  logic             strap_l0_trap,
  output logic             hit
);
  logic space_match;
  logic lvl_ok;

  // op0 = x1, crn = 1x11
  assign space_match = op0[0] && crn[3] && crn[1] && crn[0];
  assign lvl_ok      = (cur_lvl == 2'd1) || ((cur_lvl == 2'd0) && strap_l0_trap);
  assign hit         = lvl_ok && hyp_en && trap_rsvd && space_match;
endmodule

// File: rtl/sysacc_tag_gate.sv
module sysacc_tag_gate
  import sysacc_pkg::*;
(
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             hyp_en,
  input  logic [1:0]       host_pair,
  input  logic             mon_tag_en,
  input  logic             hyp_tag_en,
  input  logic             l3_tag_en,
  input  logic             l2_tag_en,
  input  logic             l1_tag_en,
  input  logic             l2_tag_en0,
  input  logic             l1_tag_en0,
  output logic             tag_ok
);
  logic host_mode;
  logic mon_block;
  logic hyp_block;
  logic lvl_bit;

  assign host_mode = hyp_en && (host_pair == 2'b11);
  assign mon_block = !mon_tag_en && (cur_lvl != 2'd3);
  assign hyp_block = !hyp_tag_en && (cur_lvl <= 2'd1) && hyp_en && (host_pair != 2'b11);

  always_comb begin
    unique case (cur_lvl)
      2'd3:    lvl_bit = l3_tag_en;
      2'd2:    lvl_bit = l2_tag_en;
      2'd1:    lvl_bit = l1_tag_en;
      default: lvl_bit = host_mode ? l2_tag_en0 : l1_tag_en0;
    endcase
  end

  assign tag_ok = !mon_block && !hyp_block && lvl_bit;
endmodule

// File: rtl/sysacc_priv_checker.sv
module sysacc_priv_checker
  import sysacc_pkg::*;
#(
  parameter int                SYN_W      = 6,
  parameter logic [SYN_W-1:0]  TRAP_CLASS = 6'h18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op0,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             secure,
  input  logic             hyp_en,
  input  logic             trap_rsvd,
  input  logic             nv_bit,
  input  logic [1:0]       host_pair,
  input  logic             feat_vhe,
  input  logic             feat_nv,
  input  logic             strap_l0_trap,
  input  logic             mon_tag_en,
  input  logic             hyp_tag_en,
  input  logic             l3_tag_en,
  input  logic             l2_tag_en,
  input  logic             l1_tag_en,
  input  logic             l2_tag_en0,
  input  logic             l1_tag_en0,
  output logic             allowed,
  output logic             undef,
  output logic             trap_l2,
  output logic [SYN_W-1:0] syndrome,
  output logic             tag_ok
);
  acc_dec_t dec;
  logic     rsvd_hit;
  logic     below_min;
  logic     nv_escape;
  logic     undef_c;
  logic     tag_c;

  sysacc_min_level u_min (
    .op1      (op1),
    .feat_vhe (feat_vhe),
    .dec      (dec)
  );

  sysacc_rsvd_trap u_rsvd (
    .cur_lvl       (cur_lvl),
    .op0           (op0),
    .crn           (crn),
    .hyp_en        (hyp_en),
    .trap_rsvd     (trap_rsvd),
    .strap_l0_trap (strap_l0_trap),
    .hit           (rsvd_hit)
  );

  sysacc_tag_gate u_tag (
    .cur_lvl    (cur_lvl),
    .hyp_en     (hyp_en),
    .host_pair  (host_pair),
    .mon_tag_en (mon_tag_en),
    .hyp_tag_en (hyp_tag_en),
    .l3_tag_en  (l3_tag_en),
    .l2_tag_en  (l2_tag_en),
    .l1_tag_en  (l1_tag_en),
    .l2_tag_en0 (l2_tag_en0),
    .l1_tag_en0 (l1_tag_en0),
    .tag_ok     (tag_c)
  );

  assign below_min = cur_lvl < dec.min_lvl;
  assign nv_escape = feat_nv && (dec.min_lvl == 2'd2) && (cur_lvl == 2'd1)
                     && hyp_en && nv_bit;
  // Secure-only check applies once the level floor is met.
  assign undef_c   = dec.feat_gap
                     || (below_min ? !nv_escape : (dec.need_sec && !secure));

  // Priority: trap, then undefined, then allowed.
  always_ff @(posedge clk) begin
    if (rst) begin
      allowed  <= 1'b0;
      undef    <= 1'b0;
      trap_l2  <= 1'b0;
      syndrome <= '0;
      tag_ok   <= 1'b0;
    end else begin
      trap_l2  <= rsvd_hit;
      undef    <= !rsvd_hit && undef_c;
      allowed  <= !rsvd_hit && !undef_c;
      syndrome <= rsvd_hit ? TRAP_CLASS : '0;
      tag_ok   <= tag_c;
    end
  end

  // R9: exactly one verdict once out of reset
  assert_one_verdict_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones({allowed, undef, trap_l2}) == 1));

  // R3: a trap always carries the fixed class
  assert_trap_class_R3: assert property (@(posedge clk) disable iff (rst)
    trap_l2 |-> (syndrome == TRAP_CLASS));

  // R4: traps only come from levels 0 and 1
  assert_trap_level_R4: assert property (@(posedge clk) disable iff (rst)
    trap_l2 |-> ($past(cur_lvl) <= 2'd1));

  // R5: level-3 class is allowed only at level 3
  assert_l3_class_R5: assert property (@(posedge clk) disable iff (rst)
    (allowed && $past(op1) == 3'b110) |-> ($past(cur_lvl) == 2'd3));

  // R10: monitor gate closes tag access below level 3
  assert_mon_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tag_ok) |-> (($past(cur_lvl) == 2'd3) || $past(mon_tag_en)));
endmodule

// File: tb/sysacc_priv_checker_tb_top.sv
module sysacc_priv_checker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [1:0] lvl;
    logic       sec, hyp, trs, nv;
    logic [1:0] host;
    logic       fvhe, fnv, strap;
    logic       mon, hta, t3, t2, t1, t20, t10;
  } vec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  vec_t v;
  logic allowed, undef, trap_l2, tag_ok;
  logic [5:0] syndrome;
  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysacc_priv_checker dut_i (
    .clk(clk), .rst(rst), .op0(v.op0), .op1(v.op1), .crn(v.crn),
    .cur_lvl(v.lvl), .secure(v.sec), .hyp_en(v.hyp), .trap_rsvd(v.trs),
    .nv_bit(v.nv), .host_pair(v.host), .feat_vhe(v.fvhe), .feat_nv(v.fnv),
    .strap_l0_trap(v.strap), .mon_tag_en(v.mon), .hyp_tag_en(v.hta),
    .l3_tag_en(v.t3), .l2_tag_en(v.t2), .l1_tag_en(v.t1),
    .l2_tag_en0(v.t20), .l1_tag_en0(v.t10),
    .allowed(allowed), .undef(undef), .trap_l2(trap_l2),
    .syndrome(syndrome), .tag_ok(tag_ok)
  );

  // Reference model: verdict 2=trap, 1=undef, 0=allowed
  function automatic int ref_verdict(vec_t x);
    int lvl = int'(x.lvl);
    int minl;
    bit sec_only = 0;
    bit gap = 0;
    if (lvl <= 1 && x.hyp && x.trs && x.op0[0] && x.crn[3] && x.crn[1] && x.crn[0]
        && (lvl == 1 || x.strap))
      return 2;
    case (x.op1)
      3'd3: minl = 0;
      3'd4: minl = 2;
      3'd5: begin minl = 2; gap = !x.fvhe; end
      3'd6: minl = 3;
      3'd7: begin minl = 1; sec_only = 1; end
      default: minl = 1;
    endcase
    if (gap) return 1;
    if (lvl < minl) begin
      if (x.fnv && minl == 2 && lvl == 1 && x.hyp && x.nv) return 0;
      return 1;
    end
    if (sec_only && !x.sec) return 1;
    return 0;
  endfunction

  function automatic bit ref_tag(vec_t x);
    bit host11 = x.hyp && x.host == 2'b11;
    if (!x.mon && x.lvl != 2'd3) return 0;
    if (!x.hta && x.lvl <= 2'd1 && x.hyp && !host11) return 0;
    case (x.lvl)
      2'd3: return x.t3;
      2'd2: return x.t2;
      2'd1: return x.t1;
      default: return host11 ? x.t20 : x.t10;
    endcase
  endfunction

  function automatic string verdict_req(vec_t x, int vd);
    if (vd == 2) return (x.lvl == 2'd0) ? "R4" : "R3";
    if (x.op1 == 3'd5) return "R6";
    if (x.op1 == 3'd7) return "R7";
    if (x.lvl == 2'd1 && x.fnv && x.nv && x.hyp && (x.op1 == 3'd4 || x.op1 == 3'd5)) return "R8";
    return "R5";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(vec_t x);
    int vd;
    int exp_vec;
    int act_vec;
    @(negedge clk);
    v = x;
    @(negedge clk);
    vd = ref_verdict(x);
    exp_vec = (vd == 2) ? 4 : (vd == 1) ? 2 : 1;
    act_vec = {29'd0, trap_l2, undef, allowed};
    check(verdict_req(x, vd), "verdict{trap,undef,allow}", act_vec, exp_vec);
    check("R9", "onehot", $countones({allowed, undef, trap_l2}), 1);
    check(vd == 2 ? "R3" : "R9", "syndrome", int'(syndrome), vd == 2 ? 24 : 0);
    check((x.mon && (x.hta || x.lvl > 2'd1 || !x.hyp || x.host == 2'b11)) ? "R11" : "R10",
          "tag_ok", int'(tag_ok), int'(ref_tag(x)));
  endtask

  function automatic vec_t rnd_vec();
    vec_t r;
    r = vec_t'({$urandom, $urandom});
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t b;
    b = '0;
    v = '0;
    v.op1 = 3'd3;
    v.mon = 1'b1;
    v.t10 = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset holds all outputs low despite inputs that would allow
    check("R1", "reset outputs", int'({allowed, undef, trap_l2, syndrome, tag_ok}), 0);
    rst = 1'b0;
    @(negedge clk);
    // R2: output captured at an edge; change inputs and look before next edge
    check("R2", "allowed after edge", int'(allowed), 1);
    v.op1 = 3'd6;
    #1;
    check("R2", "no change between edges", int'({allowed, undef}), 2);
    @(negedge clk);
    check("R2", "updated at edge", int'({allowed, undef}), 1);

    // Sweep op1 x level x security under several control patterns
    for (int k = 0; k < 8; k++) begin
      for (int lv = 0; lv < 4; lv++) begin
        for (int s = 0; s < 2; s++) begin
          for (int o = 0; o < 8; o++) begin
            b = '0;
            b.op1 = 3'(o); b.lvl = 2'(lv); b.sec = s[0];
            b.hyp = k[0]; b.trs = k[1]; b.nv = k[2]; b.fnv = k[2];
            b.fvhe = k[0] ^ k[1]; b.strap = k[1] & k[2];
            b.op0 = 2'b01; b.crn = (k[1]) ? 4'b1011 : 4'b0111;
            b.host = 2'(k); b.mon = k[0] | k[2]; b.hta = k[1];
            b.t3 = 1; b.t2 = k[0]; b.t1 = 1; b.t20 = k[1]; b.t10 = k[2];
            apply(b);
          end
        end
      end
    end

    // Directed overlap: trap and undefined together
    b = '0; b.lvl = 2'd1; b.hyp = 1; b.trs = 1; b.op0 = 2'b11; b.crn = 4'b1111;
    b.op1 = 3'd6; apply(b);                        // R3 overrides undefined
    b.lvl = 2'd0; b.strap = 0; b.op1 = 3'd3; apply(b); // R4 falls through to allowed
    b.strap = 1; b.op1 = 3'd4; apply(b);             // R4 traps
    b = '0; b.lvl = 2'd1; b.hyp = 1; b.nv = 1; b.fnv = 1; b.op1 = 3'd4; apply(b); // R8
    b.fnv = 0; apply(b);                             // R8 escape needs feature
    b = '0; b.lvl = 2'd3; b.op1 = 3'd5; b.fvhe = 0; apply(b); // R6
    b.op1 = 3'd7; b.sec = 0; apply(b);               // R7
    b.sec = 1; apply(b);                             // R7 secure allowed

    for (int i = 0; i < 3000; i++) apply(rnd_vec());

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule